// File: doc/BRIEF.md
# Converter Power-Mode Controller

This block holds the power-state logic of a serial sampling converter. It watches two asynchronous control inputs, the convert-start strobe and the serial clock. It decides whether the converter is active, napping (core powered down, reference kept alive) or sleeping (reference powered down as well). Both inputs are brought into a fast system clock domain through synchronisers, and the block detects their rising edges there.

The power state follows a count of convert-start rising edges that arrive with no serial-clock rising edge between them. Any serial-clock rising edge clears that count and returns the block to active. A wake from sleep also starts a settle interval, counted in system clocks, during which the reference-ready output stays low. A wake from nap leaves the reference ready throughout, so a conversion can follow at once.

Top module: `conv_power_ctrl`

## Requirements
- R1: After reset the block is active (activeFlag high, napFlag and sleepFlag low), refReady is high and the edge count is zero.
- R2: Two convert-start rising edges with no serial-clock rising edge between them move the block from active to nap. The nap flag rises three system clocks after the clock edge that first samples the second convert-start rise.
- R3: Four or more such convert-start rising edges put the block into sleep. The count saturates at four, so further convert-start edges keep the block asleep and add nothing.
- R4: A serial-clock rising edge clears the edge count to zero. A single convert-start edge after it leaves the block active, and the next one puts it into nap.
- R5: A serial-clock rising edge wakes the block from nap to active two system clocks after the clock edge that first samples it. refReady stays high throughout nap and that wake.
- R6: On a wake from sleep, refReady stays low for SETTLE_CYCLES system clocks after the block turns active. It rises SETTLE_CYCLES+2 clock edges after the edge that first samples the serial-clock rise.
- R7: refReady is low for every cycle the block is asleep.
- R8: Exactly one of activeFlag, napFlag and sleepFlag is high in every cycle.
- R9: When a convert-start rise and a serial-clock rise are detected in the same cycle, the serial-clock edge wins. The count is cleared and that convert-start edge is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convIn | input | 1 | Convert-start strobe, asynchronous |
| sckIn | input | 1 | Serial clock, asynchronous |
| activeFlag | output | 1 | Block is in the active state |
| napFlag | output | 1 | Block is in the nap state |
| sleepFlag | output | 1 | Block is in the sleep state |
| refReady | output | 1 | Reference is powered and settled |

## Verification
The bench builds the block with SETTLE_CYCLES set to 20 and keeps the defaults of two synchroniser stages and edge thresholds of two and four. The short settle window lets the bench probe the clock edge just before and just after refReady returns, and still run hundreds of random convert/serial-clock event sequences. With the default value that window would take 200000 clocks per wake. The directed cases cover the exact nap-wake and sleep-wake latencies, count saturation beyond four edges, and coincident edges on both inputs.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  // One-hot power state; the bit pattern is driven straight to the flags.
  typedef enum logic [2:0] {
    PWR_ACTIVE = 3'b001,
    PWR_NAP    = 3'b010,
    PWR_SLEEP  = 3'b100
  } pwrState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clearCount;
    logic loadSettle;
  } ctrlStrobe_t;

  localparam int IN_CONV = 0;
  localparam int IN_SCK  = 1;
  localparam int IN_NUM  = 2;

endpackage

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int SLEEP_EDGES   = 4,
  parameter int SETTLE_CYCLES = 200000,
  parameter int CNT_W         = 3,
  parameter int SETTLE_W      = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convIn,
  input  logic             sckIn,
  input  ctrlStrobe_t      strobe,
  output logic             sckRise,
  output logic [CNT_W-1:0] edgeCount,
  output logic             settleDone
);

  localparam logic [CNT_W-1:0]    SLEEP_LIM  = CNT_W'(SLEEP_EDGES);
  localparam logic [SETTLE_W-1:0] SETTLE_VAL = SETTLE_W'(SETTLE_CYCLES);

  logic [IN_NUM-1:0] rawIn;
  logic [IN_NUM-1:0] riseVec;
  logic [SYNC_STAGES:0] syncQ [IN_NUM];
  logic convRise;
  logic [SETTLE_W-1:0] settleQ;

  assign rawIn[IN_CONV] = convIn;
  assign rawIn[IN_SCK]  = sckIn;

  // Synchroniser chain plus one history flop per input.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < IN_NUM; i++) syncQ[i] <= '0;
    end else begin
      for (int i = 0; i < IN_NUM; i++)
        syncQ[i] <= {syncQ[i][SYNC_STAGES-1:0], rawIn[i]};
    end
  end

  genvar g;
  generate
    for (g = 0; g < IN_NUM; g++) begin : genEdge
      assign riseVec[g] = syncQ[g][SYNC_STAGES-1] & ~syncQ[g][SYNC_STAGES];
    end
  endgenerate

  assign convRise = riseVec[IN_CONV];
  assign sckRise  = riseVec[IN_SCK];

  // Saturating count of convert edges since the last serial-clock edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    edgeCount <= '0;
    else if (strobe.clearCount)                   edgeCount <= '0;
    else if (convRise && edgeCount < SLEEP_LIM)   edgeCount <= edgeCount + 1'b1;
  end

  // Reference settle down-counter, zero means settled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  settleQ <= '0;
    else if (strobe.loadSettle) settleQ <= SETTLE_VAL;
    else if (settleQ != '0)     settleQ <= settleQ - 1'b1;
  end

  assign settleDone = (settleQ == '0);

  assert_count_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCount |=> (edgeCount == '0));

  assert_count_sat_R3: assert property (@(posedge clk) disable iff (!rstN)
    edgeCount <= SLEEP_LIM);

  assert_settle_decay_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadSettle && settleQ != '0) |=> (settleQ == $past(settleQ) - 1'b1));

endmodule

// File: rtl/cpm_control.sv
module cpm_control
  import cpm_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int NAP_EDGES   = 2,
  parameter int SLEEP_EDGES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckRise,
  input  logic [CNT_W-1:0] edgeCount,
  input  logic             settleDone,
  output ctrlStrobe_t      strobe,
  output pwrState_e        pwrState,
  output logic             refReady
);

  localparam logic [CNT_W-1:0] NAP_LIM   = CNT_W'(NAP_EDGES);
  localparam logic [CNT_W-1:0] SLEEP_LIM = CNT_W'(SLEEP_EDGES);

  pwrState_e stateQ, stateD;

  always_comb begin
    stateD            = stateQ;
    strobe            = '0;
    strobe.clearCount = sckRise;
    if (sckRise) begin
      stateD            = PWR_ACTIVE;
      strobe.loadSettle = (stateQ == PWR_SLEEP);
    end else begin
      case (stateQ)
        PWR_ACTIVE: begin
          if (edgeCount >= SLEEP_LIM)    stateD = PWR_SLEEP;
          else if (edgeCount >= NAP_LIM) stateD = PWR_NAP;
        end
        PWR_NAP:   if (edgeCount >= SLEEP_LIM) stateD = PWR_SLEEP;
        PWR_SLEEP: stateD = PWR_SLEEP;
        default:   stateD = PWR_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= PWR_ACTIVE;
    else       stateQ <= stateD;
  end

  assign pwrState = stateQ;
  assign refReady = (stateQ != PWR_SLEEP) && settleDone;

  assert_state_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(stateQ));

  assert_nap_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PWR_ACTIVE && !sckRise && edgeCount == NAP_LIM) |=> (stateQ == PWR_NAP));

  assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!sckRise && edgeCount >= SLEEP_LIM) |=> (stateQ == PWR_SLEEP));

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    sckRise |=> (stateQ == PWR_ACTIVE));

  assert_ref_low_sleep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PWR_SLEEP) |-> !refReady);

  assert_settle_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PWR_SLEEP && sckRise) |=> (stateQ == PWR_ACTIVE && !refReady));

endmodule

// File: rtl/conv_power_ctrl.sv
module conv_power_ctrl
  import cpm_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int NAP_EDGES     = 2,
  parameter int SLEEP_EDGES   = 4,
  parameter int SETTLE_CYCLES = 200000
) (
  input  logic clk,
  input  logic rstN,
  input  logic convIn,
  input  logic sckIn,
  output logic activeFlag,
  output logic napFlag,
  output logic sleepFlag,
  output logic refReady
);

  localparam int CNT_W    = $clog2(SLEEP_EDGES + 1);
  localparam int SETTLE_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);

  ctrlStrobe_t      strobe;
  logic             sckRise;
  logic [CNT_W-1:0] edgeCount;
  logic             settleDone;
  pwrState_e        pwrState;

  cpm_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .SLEEP_EDGES  (SLEEP_EDGES),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .CNT_W        (CNT_W),
    .SETTLE_W     (SETTLE_W)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .convIn    (convIn),
    .sckIn     (sckIn),
    .strobe    (strobe),
    .sckRise   (sckRise),
    .edgeCount (edgeCount),
    .settleDone(settleDone)
  );

  cpm_control #(
    .CNT_W      (CNT_W),
    .NAP_EDGES  (NAP_EDGES),
    .SLEEP_EDGES(SLEEP_EDGES)
  ) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .sckRise   (sckRise),
    .edgeCount (edgeCount),
    .settleDone(settleDone),
    .strobe    (strobe),
    .pwrState  (pwrState),
    .refReady  (refReady)
  );

  assign activeFlag = (pwrState == PWR_ACTIVE);
  assign napFlag    = (pwrState == PWR_NAP);
  assign sleepFlag  = (pwrState == PWR_SLEEP);

endmodule

// File: tb/tb_conv_power_ctrl.sv
`timescale 1ns/1ps
module tb_conv_power_ctrl;

  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convIn = 1'b0;
  logic sckIn = 1'b0;
  logic activeFlag, napFlag, sleepFlag, refReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model: edge count and state (0 active, 1 nap, 2 sleep).
  int mCnt = 0;
  int mState = 0;

  always #5 clk = ~clk;

  conv_power_ctrl #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .convIn(convIn), .sckIn(sckIn),
    .activeFlag(activeFlag), .napFlag(napFlag), .sleepFlag(sleepFlag),
    .refReady(refReady)
  );

  function automatic logic [2:0] flagsOf(int st);
    case (st)
      0:       return 3'b100;
      1:       return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {active,nap,sleep,ready} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chkModel(string tag, bit readyExp);
    chk(tag, {activeFlag, napFlag, sleepFlag, refReady}, {flagsOf(mState), readyExp});
  endtask

  task automatic pulse(bit doConv, bit doSck);
    @(negedge clk);
    convIn = doConv; sckIn = doSck;
    repeat (2) @(negedge clk);
    convIn = 1'b0; sckIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic convEvent();
    pulse(1'b1, 1'b0);
    if (mCnt < 4) mCnt++;
    if (mCnt >= 4) mState = 2;
    else if (mCnt >= 2 && mState == 0) mState = 1;
  endtask

  // Serial-clock event; a wake from sleep checks the settle window coarsely.
  task automatic sckEvent(string tag);
    bit wasSleep;
    wasSleep = (mState == 2);
    pulse(1'b0, 1'b1);
    mCnt = 0; mState = 0;
    if (wasSleep) begin
      chkModel({tag, " R6 settling"}, 1'b0);
      repeat (SETTLE + 4) @(negedge clk);
      chkModel({tag, " R6 settled"}, 1'b1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {activeFlag, napFlag, sleepFlag, refReady}, 4'b1001);

    // R1: a single convert edge after reset leaves it active.
    convEvent();
    chkModel("R1 one edge after reset", 1'b1);
    // R2: second edge gives nap, reference stays ready.
    convEvent();
    chkModel("R2 nap after two edges", 1'b1);

    // R5: exact nap-wake latency.
    @(negedge clk); sckIn = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5 nap held one edge after sample", {activeFlag, napFlag, sleepFlag, refReady}, 4'b0101);
    @(posedge clk); @(negedge clk);
    chk("R5 active two edges after sample", {activeFlag, napFlag, sleepFlag, refReady}, 4'b1001);
    sckIn = 1'b0;
    repeat (3) @(negedge clk);
    mCnt = 0; mState = 0;

    // R2: exact nap-entry latency.
    convEvent();
    @(negedge clk); convIn = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 active two edges after sample", {activeFlag, napFlag, sleepFlag, refReady}, 4'b1001);
    @(posedge clk); @(negedge clk);
    chk("R2 nap three edges after sample", {activeFlag, napFlag, sleepFlag, refReady}, 4'b0101);
    convIn = 1'b0;
    repeat (3) @(negedge clk);
    mCnt = 2; mState = 1;

    // R3 / R7: into sleep, then saturation with extra edges.
    convEvent(); chkModel("R3 nap at three edges", 1'b1);
    convEvent(); chkModel("R3 R7 sleep at four edges", 1'b0);
    convEvent(); convEvent();
    chkModel("R3 R7 sleep holds after six edges", 1'b0);

    // R6: exact settle window after a wake from sleep.
    @(negedge clk); sckIn = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R6 active with ref low", {activeFlag, napFlag, sleepFlag, refReady}, 4'b1000);
    repeat (SETTLE - 1) @(posedge clk); @(negedge clk);
    chk("R6 ref still low at last settle cycle", {activeFlag, napFlag, sleepFlag, refReady}, 4'b1000);
    @(posedge clk); @(negedge clk);
    chk("R6 ref high after settle", {activeFlag, napFlag, sleepFlag, refReady}, 4'b1001);
    sckIn = 1'b0;
    repeat (3) @(negedge clk);
    mCnt = 0; mState = 0;

    // R4: saturated count was cleared, not decremented.
    convEvent(); chkModel("R4 one edge after clear stays active", 1'b1);
    sckEvent("R4");
    convEvent(); chkModel("R4 edge after sck stays active", 1'b1);
    convEvent(); chkModel("R4 second edge after sck gives nap", 1'b1);
    sckEvent("R5");
    chkModel("R5 wake from nap keeps ref", 1'b1);

    // R9: coincident edges, serial clock wins.
    convEvent();
    pulse(1'b1, 1'b1);
    mCnt = 0; mState = 0;
    chkModel("R9 coincident edges leave active", 1'b1);
    convEvent(); chkModel("R9 coincident conv edge not counted", 1'b1);
    convEvent(); chkModel("R9 nap after two further edges", 1'b1);
    sckEvent("R9");

    // Random event mix against the model (R2 R3 R4 R5 R7 R8).
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 2) != 0) convEvent();
      else sckEvent("rand");
      chkModel("R2 R3 R4 R7 random", mState != 2);
      checks++;
      if ($countones({activeFlag, napFlag, sleepFlag}) != 1) begin
        errors++;
        $display("FAIL R8 onehot: actual=%b expected=one bit", {activeFlag, napFlag, sleepFlag});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule